// File: doc/BRIEF.md
# Video write queue with drain latency

This block is a small write queue that sits between a processor or DMA data port and the video memories. It holds up to four pending writes. Each write carries a target code, a 17-bit address and a 16-bit word. A write is sent to its memory only after it has aged for a fixed number of cycles. Writes leave strictly one at a time, in arrival order. When the video memory runs in byte-wide mode, a write aimed at it goes out as two byte writes. Colour and scroll memory writes always go out as one word.

An external DMA engine can hold back draining while it preloads. While a fill-mode DMA is waiting, every pop hands it a fill value and a one-cycle start pulse. The value is the head word when the head targets video memory. Otherwise it is the word in the slot behind the head.

The drain is a two-state machine. `ST_WHOLE` means the head entry is untouched. `ST_HIGH` means its lower byte is already written. The machine moves in three ways:
- In `ST_WHOLE`, a byte-mode video memory drain step goes to `ST_HIGH` and writes the lower byte.
- In `ST_WHOLE`, any other drain step writes the whole word, pops the entry and stays in `ST_WHOLE`.
- In `ST_HIGH`, a drain step writes the upper byte, pops the entry and returns to `ST_WHOLE`.

Top module: `vidwr_queue`

## Requirements
- R1: While `rst_n` is low, and after it is released with no push, `empty`=1, `full`=0, `mem_we`=0 and `fill_start`=0.
- R2: A write accepted at a clock edge into an empty queue, with `dma_hold` low, raises `mem_we` in the cycle after the second following edge, and never earlier.
- R3: Writes reach the memory port in acceptance order, with unchanged target code (`mem_tgt`), address and data.
- R4: `full` is 1 exactly when four entries are held. A push while `full` is 1 is dropped and never reaches the memory port.
- R5: While `dma_hold` is 1, `mem_we` stays 0. Draining resumes in the first cycle it is 0 again.
- R6: When `vram_byte_mode`=1 and the head target code is 1 (video memory), the entry drains in two steps. First comes `mem_be`=01 (lower byte), then `mem_be`=10 (upper byte), with the same address and data. Only the second step pops the entry.
- R7: Target codes other than 1, and code 1 when `vram_byte_mode`=0, drain as one write with `mem_be`=11, which pops the entry.
- R8: On a pop while `fill_pending`=1, `fill_start` is 1 in the following cycle. `fill_data` then holds the popped word if its target code was 1. Otherwise it holds the word of the next entry, or 0 when there is none.
- R9: `fill_start` is never 1 in a cycle that does not follow a pop made with `fill_pending`=1.
- R10: `empty` is 1 exactly when the head slot holds no entry, and `mem_we` is 0 whenever `empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Offer a write this cycle |
| push_tgt | input | 4 | Target code: 1 video memory, 3 colour memory, 5 scroll memory |
| push_addr | input | 17 | Write address |
| push_data | input | 16 | Write data |
| full | output | 1 | All four slots occupied |
| empty | output | 1 | Head slot unoccupied |
| vram_byte_mode | input | 1 | Video memory is byte wide |
| dma_hold | input | 1 | DMA preload in progress; blocks draining |
| fill_pending | input | 1 | A fill-mode DMA waits for its value |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | 2 | Byte lanes: 01 lower, 10 upper, 11 word |
| mem_tgt | output | 4 | Target code of the write |
| mem_addr | output | 17 | Write address |
| mem_data | output | 16 | Write data |
| fill_start | output | 1 | One-cycle pulse that starts the fill |
| fill_data | output | 16 | Fill value for the DMA |

## Verification
Each result falls due a fixed number of cycles after its stimulus:
- An accepted push changes `full` and `empty` in the cycle after its edge.
- The write it carries can reach `mem_we` no sooner than two edges later.
- The upper byte of a split write comes at the next cycle in which draining is allowed.
- `fill_start` and `fill_data` follow one cycle after the pop.

The bench drives inputs at the falling edge and compares every output one time unit later. It compares against a cycle-accurate model built from the requirements, which it advances once per rising edge. In this way each expectation is tied to the exact cycle it falls due.

// File: rtl/vidwr_pkg.sv
package vidwr_pkg;
    localparam int TGT_W  = 4;
    localparam int ADDR_W = 17;
    localparam int DATA_W = 16;

    localparam logic [TGT_W-1:0] TGT_VRAM  = 4'd1;
    localparam logic [TGT_W-1:0] TGT_CRAM  = 4'd3;
    localparam logic [TGT_W-1:0] TGT_VSRAM = 4'd5;

    typedef enum logic [0:0] {
        ST_WHOLE = 1'b0,
        ST_HIGH  = 1'b1
    } drain_st_t;

    typedef struct packed {
        logic [TGT_W-1:0]  tgt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;
endpackage

// File: rtl/vidwr_slots.sv
module vidwr_slots
    import vidwr_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int LATENCY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_en,
    input  wr_req_t           push_req,
    input  logic              pop,
    output wr_req_t           head,
    output logic [DATA_W-1:0] next_data,
    output logic              head_valid,
    output logic              head_aged,
    output logic              full
);
    localparam int LAT_W = $clog2(LATENCY + 1);
    localparam int CNT_W = $clog2(DEPTH + 1);

    wr_req_t            req_q  [DEPTH];
    wr_req_t            sh_req [DEPTH];
    wr_req_t            req_d  [DEPTH];
    logic [DEPTH-1:0]   vld_q, sh_vld, vld_d;
    logic [LAT_W-1:0]   lat_q  [DEPTH];
    logic [LAT_W-1:0]   sh_lat [DEPTH];
    logic [LAT_W-1:0]   lat_d  [DEPTH];
    logic [CNT_W-1:0]   used, wr_idx;

    // shift network: on a pop every slot takes its upper neighbour
    for (genvar g = 0; g < DEPTH; g++) begin : g_shift
        if (g < DEPTH - 1) begin : g_mid
            assign sh_req[g] = pop ? req_q[g+1] : req_q[g];
            assign sh_vld[g] = pop ? vld_q[g+1] : vld_q[g];
            assign sh_lat[g] = pop ? lat_q[g+1] : lat_q[g];
        end else begin : g_top
            assign sh_req[g] = pop ? '0   : req_q[g];
            assign sh_vld[g] = pop ? 1'b0 : vld_q[g];
            assign sh_lat[g] = pop ? '0   : lat_q[g];
        end
    end

    always_comb begin
        used = '0;
        for (int i = 0; i < DEPTH; i++) used = used + CNT_W'(vld_q[i]);
    end

    assign wr_idx = used - CNT_W'(pop);

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            req_d[i] = sh_req[i];
            vld_d[i] = sh_vld[i];
            lat_d[i] = (sh_vld[i] && sh_lat[i] != '0) ? sh_lat[i] - LAT_W'(1) : sh_lat[i];
            if (push_en && wr_idx == CNT_W'(i)) begin
                req_d[i] = push_req;
                vld_d[i] = 1'b1;
                lat_d[i] = LAT_W'(LATENCY);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                req_q[i] <= '0;
                lat_q[i] <= '0;
            end
        end else begin
            vld_q <= vld_d;
            for (int i = 0; i < DEPTH; i++) begin
                req_q[i] <= req_d[i];
                lat_q[i] <= lat_d[i];
            end
        end
    end

    assign head       = req_q[0];
    assign next_data  = req_q[1].data;
    assign head_valid = vld_q[0];
    assign head_aged  = (lat_q[0] == '0);
    assign full       = vld_q[DEPTH-1];

    AST_FULL_FROM_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> $past(push_en)); // R4
endmodule

// File: rtl/vidwr_drain_fsm.sv
module vidwr_drain_fsm
    import vidwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       head_valid,
    input  logic       head_aged,
    input  logic       hold,
    input  logic       byte_mode,
    input  wr_req_t    head,
    output logic       we,
    output logic [1:0] be,
    output logic       pop
);
    drain_st_t st_q, st_d;
    logic      go;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_WHOLE;
        else        st_q <= st_d;
    end

    assign go = head_valid && head_aged && !hold;

    always_comb begin
        st_d = st_q;
        we   = 1'b0;
        be   = 2'b00;
        pop  = 1'b0;
        unique case (st_q)
            ST_WHOLE: begin
                if (go) begin
                    we = 1'b1;
                    if (head.tgt == TGT_VRAM && byte_mode) begin
                        be   = 2'b01;
                        st_d = ST_HIGH;
                    end else begin
                        be  = 2'b11;
                        pop = 1'b1;
                    end
                end
            end
            ST_HIGH: begin
                if (go) begin
                    we   = 1'b1;
                    be   = 2'b10;
                    pop  = 1'b1;
                    st_d = ST_WHOLE;
                end
            end
            default: st_d = ST_WHOLE;
        endcase
    end

    AST_HIGH_HAS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HIGH) |-> head_valid); // R6
endmodule

// File: rtl/vidwr_fill.sv
module vidwr_fill
    import vidwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop,
    input  logic              fill_pending,
    input  logic [TGT_W-1:0]  head_tgt,
    input  logic [DATA_W-1:0] head_data,
    input  logic [DATA_W-1:0] next_data,
    output logic              fill_start,
    output logic [DATA_W-1:0] fill_data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_start <= 1'b0;
            fill_data  <= '0;
        end else begin
            fill_start <= pop && fill_pending;
            if (pop && fill_pending)
                fill_data <= (head_tgt == TGT_VRAM) ? head_data : next_data;
        end
    end

    AST_FILL_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        fill_start |-> $past(fill_pending)); // R9
endmodule

// File: rtl/vidwr_queue.sv
module vidwr_queue
    import vidwr_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int LATENCY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [TGT_W-1:0]  push_tgt,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [DATA_W-1:0] push_data,
    output logic              full,
    output logic              empty,
    input  logic              vram_byte_mode,
    input  logic              dma_hold,
    input  logic              fill_pending,
    output logic              mem_we,
    output logic [1:0]        mem_be,
    output logic [TGT_W-1:0]  mem_tgt,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              fill_start,
    output logic [DATA_W-1:0] fill_data
);
    wr_req_t           push_req, head;
    logic [DATA_W-1:0] next_data;
    logic              push_en, pop, head_valid, head_aged;

    assign push_en  = push_valid && !full;
    assign push_req = '{tgt: push_tgt, addr: push_addr, data: push_data};

    vidwr_slots #(.DEPTH(DEPTH), .LATENCY(LATENCY)) u_slots (
        .clk(clk), .rst_n(rst_n), .push_en(push_en), .push_req(push_req),
        .pop(pop), .head(head), .next_data(next_data),
        .head_valid(head_valid), .head_aged(head_aged), .full(full)
    );

    vidwr_drain_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .head_valid(head_valid), .head_aged(head_aged),
        .hold(dma_hold), .byte_mode(vram_byte_mode), .head(head),
        .we(mem_we), .be(mem_be), .pop(pop)
    );

    vidwr_fill u_fill (
        .clk(clk), .rst_n(rst_n), .pop(pop), .fill_pending(fill_pending),
        .head_tgt(head.tgt), .head_data(head.data), .next_data(next_data),
        .fill_start(fill_start), .fill_data(fill_data)
    );

    assign empty    = !head_valid;
    assign mem_tgt  = head.tgt;
    assign mem_addr = head.addr;
    assign mem_data = head.data;

    AST_EMPTY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !mem_we); // R10
    AST_LOWER_KEEPS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_be == 2'b01) |=> !empty); // R6
    AST_PUSH_AGES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(empty) && !empty) |-> !mem_we); // R2
endmodule

// File: tb/sim_vidwr_queue.sv
module sim_vidwr_queue;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0;
    logic [3:0]  push_tgt = '0;
    logic [16:0] push_addr = '0;
    logic [15:0] push_data = '0;
    logic        vram_byte_mode = 1'b0, dma_hold = 1'b0, fill_pending = 1'b0;
    logic        full, empty, mem_we, fill_start;
    logic [1:0]  mem_be;
    logic [3:0]  mem_tgt;
    logic [16:0] mem_addr;
    logic [15:0] mem_data, fill_data;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    // reference model state
    int          m_cnt = 0;
    logic [3:0]  m_tgt  [4];
    logic [16:0] m_addr [4];
    logic [15:0] m_data [4];
    int          m_lat  [4];
    bit          m_high = 1'b0;
    bit          m_fs = 1'b0;
    logic [15:0] m_fd = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vidwr_queue u0 (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_tgt(push_tgt),
        .push_addr(push_addr), .push_data(push_data), .full(full), .empty(empty),
        .vram_byte_mode(vram_byte_mode), .dma_hold(dma_hold), .fill_pending(fill_pending),
        .mem_we(mem_we), .mem_be(mem_be), .mem_tgt(mem_tgt), .mem_addr(mem_addr),
        .mem_data(mem_data), .fill_start(fill_start), .fill_data(fill_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_be(input bit go, input bit bm);
        if (!go) return 2'b00;
        if (m_high) return 2'b10;
        if (m_tgt[0] == 4'd1 && bm) return 2'b01;
        return 2'b11;
    endfunction

    task automatic step(input bit pv, input logic [3:0] pt, input logic [16:0] pa,
                        input logic [15:0] pd, input bit bm, input bit hd, input bit fp);
        bit go, e_pop, acc;
        logic [1:0] be;
        push_valid = pv; push_tgt = pt; push_addr = pa; push_data = pd;
        vram_byte_mode = bm; dma_hold = hd; fill_pending = fp;
        #1;
        go = (m_cnt > 0) && (m_lat[0] == 0) && !hd;
        be = exp_be(go, bm);
        e_pop = go && (be != 2'b01);
        chk(hd ? "R5" : "R2", 32'(mem_we), 32'(go));
        if (go) begin
            chk(be == 2'b11 ? "R7" : "R6", 32'(mem_be), 32'(be));
            chk("R3", 32'(mem_addr), 32'(m_addr[0]));
            chk("R3", 32'(mem_data), 32'(m_data[0]));
            chk("R3", 32'(mem_tgt), 32'(m_tgt[0]));
        end
        chk("R4", 32'(full), 32'(m_cnt == 4));
        chk("R10", 32'(empty), 32'(m_cnt == 0));
        chk(m_fs ? "R8" : "R9", 32'(fill_start), 32'(m_fs));
        if (m_fs) chk("R8", 32'(fill_data), 32'(m_fd));
        // advance model to the coming rising edge
        m_fs = e_pop && fp;
        if (m_fs) m_fd = (m_tgt[0] == 4'd1) ? m_data[0] : ((m_cnt > 1) ? m_data[1] : 16'h0);
        for (int i = 0; i < m_cnt; i++) if (m_lat[i] > 0) m_lat[i]--;
        acc = pv && (m_cnt < 4);
        if (e_pop) begin
            for (int i = 0; i < 3; i++) begin
                m_tgt[i] = m_tgt[i+1]; m_addr[i] = m_addr[i+1];
                m_data[i] = m_data[i+1]; m_lat[i] = m_lat[i+1];
            end
            m_cnt--; m_high = 1'b0;
        end else if (be == 2'b01) begin
            m_high = 1'b1;
        end
        if (acc) begin
            m_tgt[m_cnt] = pt; m_addr[m_cnt] = pa; m_data[m_cnt] = pd; m_lat[m_cnt] = 2;
            m_cnt++;
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n, input bit bm, input bit hd, input bit fp);
        for (int i = 0; i < n; i++) step(1'b0, 4'd0, 17'd0, 16'd0, bm, hd, fp);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd2025);
        for (int i = 0; i < 4; i++) begin m_tgt[i] = '0; m_addr[i] = '0; m_data[i] = '0; m_lat[i] = 0; end
        @(negedge clk); @(negedge clk);
        // R1 during reset
        chk("R1", 32'(empty), 32'd1);
        chk("R1", 32'(full), 32'd0);
        chk("R1", 32'(mem_we), 32'd0);
        chk("R1", 32'(fill_start), 32'd0);
        rst_n = 1'b1;
        idle(2, 1'b0, 1'b0, 1'b0);
        chk("R1", 32'(empty), 32'd1);

        // R2 / R7: single colour write, word mode, latency window
        step(1'b1, 4'd3, 17'h00040, 16'hBEEF, 1'b0, 1'b0, 1'b0);
        idle(6, 1'b0, 1'b0, 1'b0);
        // R6: byte-mode video memory write splits into two steps
        step(1'b1, 4'd1, 17'h1ABCD, 16'h1234, 1'b1, 1'b0, 1'b0);
        idle(6, 1'b1, 1'b0, 1'b0);
        // R4 / R5: fill under hold, a fifth push is dropped
        for (int i = 0; i < 5; i++)
            step(1'b1, (i % 2) ? 4'd5 : 4'd1, 17'(i * 3), 16'(16'hA000 + i), 1'b0, 1'b1, 1'b0);
        idle(4, 1'b0, 1'b1, 1'b0);
        idle(8, 1'b0, 1'b0, 1'b0);
        // R8: fill values from head or next slot
        step(1'b1, 4'd3, 17'h10, 16'h1111, 1'b0, 1'b0, 1'b1);
        step(1'b1, 4'd1, 17'h11, 16'h2222, 1'b0, 1'b0, 1'b1);
        step(1'b1, 4'd5, 17'h12, 16'h3333, 1'b0, 1'b0, 1'b1);
        idle(8, 1'b0, 1'b0, 1'b1);
        step(1'b1, 4'd3, 17'h13, 16'h4444, 1'b0, 1'b0, 1'b1);
        idle(6, 1'b1, 1'b0, 1'b1);

        // constrained random mix
        for (int c = 0; c < 4000; c++) begin
            logic [3:0] t;
            int r;
            r = $urandom_range(0, 3);
            t = (r == 0) ? 4'd3 : (r == 1) ? 4'd5 : (r == 2) ? 4'd1 : 4'd7;
            step($urandom_range(0, 99) < 45, t, 17'($urandom), 16'($urandom),
                 $urandom_range(0, 1) == 1, $urandom_range(0, 99) < 15,
                 $urandom_range(0, 99) < 40);
        end
        idle(10, 1'b0, 1'b0, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule